// File: doc/BRIEF.md
# AHB-Lite Unmapped Address Error Responder

This block sits in the address decode path of an AHB-Lite interconnect. Every address on the bus is compared against a parameterised table of implemented slave regions. Each region has a base and a power-of-two size aligned to that base. When the address hits a region, the block raises the select line of exactly one slave. When it hits none, no select line is raised, so no slave sees the transfer.

If a real transfer (NONSEQ or SEQ) is accepted to an unmapped address, the block claims the data phase itself. It answers with the two-cycle AHB ERROR response and returns zero on the read data bus. It also sets a sticky status flag, which a register block can read and clear through a single clear input. IDLE and BUSY transfers to unmapped addresses receive a zero-wait OKAY response and leave the flag alone. When the block does not own a data phase, it drives a ready, OKAY response. This lets its outputs be merged into the interconnect's response multiplexer as a default slave.

Top module: `unmapResponder`

## Requirements
- R1: With the default table (region 0: 0x0000_0000 of 64 KiB; region 1: 0x2000_0000 of 4 KiB; region 2: 0x4000_0000 of 256 B; region 3: 0x4000_0000 of 64 KiB), `slaveSel` bit i is high only for the lowest-numbered region whose range contains `haddr`, so at most one bit is ever set.
- R2: An address outside every region drives `slaveSel` to all zeros, whatever the transfer type, so no write can reach a slave.
- R3: An accepted transfer (`hreadyIn` high, `htrans` NONSEQ=2'b10 or SEQ=2'b11) to an unmapped address gives, in the next cycle, `hreadyOut`=0 with `hresp`=1, and in the cycle after that `hreadyOut`=1 with `hresp`=1.
- R4: `hrdata` reads zero, including the completing cycle of an erroring read.
- R5: IDLE (2'b00) or BUSY (2'b01) transfers to unmapped addresses get `hreadyOut`=1 and `hresp`=0 in the next cycle and do not set the flag.
- R6: A transfer to a mapped address leaves this block's response at `hreadyOut`=1, `hresp`=0.
- R7: `unmappedFlag` rises in the cycle after an accepted unmapped transfer and holds until cleared.
- R8: `unmappedClr` high at a clock edge clears the flag, except when an unmapped transfer is accepted at the same edge, in which case the flag is set.
- R9: During and right after reset, `hreadyOut`=1, `hresp`=0 and `unmappedFlag`=0.
- R10: An unmapped NONSEQ presented while `hreadyIn` is low is not accepted: the next cycle is OKAY and the flag is unchanged.
- R11: An unmapped transfer accepted in the second ERROR cycle starts a new two-cycle ERROR response straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haddr | input | ADDR_W | Address-phase address |
| htrans | input | 2 | Address-phase transfer type |
| hreadyIn | input | 1 | Bus-wide ready; address phase is accepted when high |
| slaveSel | output | NUM_REGIONS | One-hot slave select, zero on a miss |
| hreadyOut | output | 1 | This block's ready for its own data phase |
| hresp | output | 1 | This block's response, 1 = ERROR |
| hrdata | output | DATA_W | Read data for unmapped reads, always zero |
| unmappedFlag | output | 1 | Sticky unmapped-access status |
| unmappedClr | input | 1 | Clear pulse for the status flag |

## Verification
The bound checker covers, on every cycle, the timing of the two ERROR beats after an accepted miss, the OKAY response after anything else, the at-most-one-hot select, and the rules for holding, clearing and setting the flag, with set winning over clear. Some behaviours only the bench's scenarios can show. These are the decode of each region at its edges and the priority between the overlapping regions. They also include the zero read data, the miss that is ignored while ready is low, and back-to-back errors started in the second ERROR beat.

// File: rtl/unmapRespPkg.sv
package unmapRespPkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transKindE;

  typedef enum logic [1:0] {
    PH_FREE = 2'b00,
    PH_WAIT = 2'b01,
    PH_LAST = 2'b10
  } errPhaseE;

  // Strobes from control to datapath
  typedef struct packed {
    logic setFlag;   // an unmapped transfer is being claimed this edge
    logic stretch;   // hold the bus: first error beat
    logic flagErr;   // drive ERROR on hresp
  } ctrlStrobeT;

endpackage

// File: rtl/unmapRegionCmp.sv
module unmapRegionCmp #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int SIZE_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Size is a power of two aligned to the base: compare the bits above the size
  localparam logic [ADDR_W-1:0] TAG = BASE >> SIZE_LOG2;

  always_comb begin
    hit = ((addr >> SIZE_LOG2) == TAG);
  end
endmodule

// File: rtl/unmapDatapath.sv
module unmapDatapath
  import unmapRespPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [NUM_REGIONS*8-1:0]      REGION_LOG2 = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      haddr,
  input  ctrlStrobeT             strobe,
  input  logic                   unmappedClr,
  output logic                   addrMiss,
  output logic [NUM_REGIONS-1:0] slaveSel,
  output logic                   hreadyOut,
  output logic                   hresp,
  output logic [DATA_W-1:0]      hrdata,
  output logic                   unmappedFlag
);
  logic [NUM_REGIONS-1:0] regionHit;

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
    localparam logic [ADDR_W-1:0] RB = REGION_BASE[gi*ADDR_W +: ADDR_W];
    localparam int RL = int'(REGION_LOG2[gi*8 +: 8]);
    unmapRegionCmp #(
      .ADDR_W   (ADDR_W),
      .BASE     (RB),
      .SIZE_LOG2(RL)
    ) u_cmp (
      .addr(haddr),
      .hit (regionHit[gi])
    );
  end

  // Lowest index wins where regions overlap
  always_comb begin
    logic found;
    found    = 1'b0;
    slaveSel = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regionHit[i] && !found) begin
        slaveSel[i] = 1'b1;
        found       = 1'b1;
      end
    end
    addrMiss = !found;
  end

  // Sticky status: set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unmappedFlag <= 1'b0;
    end else if (strobe.setFlag) begin
      unmappedFlag <= 1'b1;
    end else if (unmappedClr) begin
      unmappedFlag <= 1'b0;
    end
  end

  always_comb begin
    hreadyOut = !strobe.stretch;
    hresp     = strobe.flagErr;
    hrdata    = '0;
  end
endmodule

// File: rtl/unmapControl.sv
module unmapControl
  import unmapRespPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  transKindE  transKind,
  input  logic       hreadyIn,
  input  logic       addrMiss,
  output ctrlStrobeT strobe
);
  errPhaseE phase, phaseNext;
  logic     realXfer;
  logic     claim;

  always_comb begin
    realXfer = (transKind == TR_NONSEQ) || (transKind == TR_SEQ);
    claim    = hreadyIn && realXfer && addrMiss && (phase != PH_WAIT);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_FREE: phaseNext = claim ? PH_WAIT : PH_FREE;
      PH_WAIT: phaseNext = PH_LAST;
      PH_LAST: phaseNext = claim ? PH_WAIT : PH_FREE;
      default: phaseNext = PH_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_FREE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe.setFlag = claim;
    strobe.stretch = (phase == PH_WAIT);
    strobe.flagErr = (phase == PH_WAIT) || (phase == PH_LAST);
  end
endmodule

// File: rtl/unmapResponder.sv
module unmapResponder
  import unmapRespPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE =
    {32'h4000_0000, 32'h4000_0000, 32'h2000_0000, 32'h0000_0000},
  parameter logic [NUM_REGIONS*8-1:0] REGION_LOG2 =
    {8'd16, 8'd8, 8'd12, 8'd16}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      haddr,
  input  logic [1:0]             htrans,
  input  logic                   hreadyIn,
  output logic [NUM_REGIONS-1:0] slaveSel,
  output logic                   hreadyOut,
  output logic                   hresp,
  output logic [DATA_W-1:0]      hrdata,
  output logic                   unmappedFlag,
  input  logic                   unmappedClr
);
  ctrlStrobeT strobe;
  logic       addrMiss;

  unmapControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .transKind(transKindE'(htrans)),
    .hreadyIn (hreadyIn),
    .addrMiss (addrMiss),
    .strobe   (strobe)
  );

  unmapDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_REGIONS(NUM_REGIONS),
    .REGION_BASE(REGION_BASE),
    .REGION_LOG2(REGION_LOG2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .haddr       (haddr),
    .strobe      (strobe),
    .unmappedClr (unmappedClr),
    .addrMiss    (addrMiss),
    .slaveSel    (slaveSel),
    .hreadyOut   (hreadyOut),
    .hresp       (hresp),
    .hrdata      (hrdata),
    .unmappedFlag(unmappedFlag)
  );
endmodule

// File: rtl/unmapResponderChk.sv
module unmapResponderChk #(
  parameter int NUM_REGIONS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             htrans,
  input logic                   hreadyIn,
  input logic [NUM_REGIONS-1:0] slaveSel,
  input logic                   hreadyOut,
  input logic                   hresp,
  input logic                   unmappedFlag,
  input logic                   unmappedClr
);
  logic missAcc;
  always_comb missAcc = hreadyIn && hreadyOut && htrans[1] && (slaveSel == '0);

  // R1: never more than one slave selected
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slaveSel));

  // R3: first error beat follows an accepted miss
  assert_err_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    missAcc |=> (!hreadyOut && hresp));

  // R3: second error beat follows the first
  assert_err_second_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hreadyOut && hresp) |=> (hreadyOut && hresp));

  // R5/R6: anything else accepted while ready gets OKAY
  assert_okay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hreadyIn && hreadyOut && !missAcc) |=> (hreadyOut && !hresp));

  // R7: flag holds without set or clear
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!missAcc && !unmappedClr) |=> $stable(unmappedFlag));

  // R8: set wins over clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    missAcc |=> unmappedFlag);

  // R8: clear alone empties the flag
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (unmappedClr && !missAcc) |=> !unmappedFlag);
endmodule

bind unmapResponder unmapResponderChk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .htrans      (htrans),
  .hreadyIn    (hreadyIn),
  .slaveSel    (slaveSel),
  .hreadyOut   (hreadyOut),
  .hresp       (hresp),
  .unmappedFlag(unmappedFlag),
  .unmappedClr (unmappedClr)
);

// File: tb/unmapResponder_tb.sv
`timescale 1ns/1ps
module unmapResponder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        stall = 1'b0;
  logic        hreadyIn;
  logic [3:0]  slaveSel;
  logic        hreadyOut;
  logic        hresp;
  logic [31:0] hrdata;
  logic        unmappedFlag;
  logic        unmappedClr = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign hreadyIn = hreadyOut && !stall;

  unmapResponder u_dut (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans),
    .hreadyIn(hreadyIn), .slaveSel(slaveSel), .hreadyOut(hreadyOut),
    .hresp(hresp), .hrdata(hrdata), .unmappedFlag(unmappedFlag),
    .unmappedClr(unmappedClr)
  );

  typedef struct {
    int          cyc;
    int          kind;  // 0 sel, 1 {ready,resp}, 2 flag, 3 rdata
    logic [31:0] val;
    string       tag;
  } expT;

  expT  q[$];
  int   cycNow = 0;
  int   checks = 0;
  int   errors = 0;
  logic expFlag = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cycNow <= cycNow + 1;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench-side decode taken from R1/R2
  function automatic logic [3:0] refSel(input logic [31:0] a);
    if (a[31:16] == 16'h0000)       return 4'b0001;
    if (a[31:12] == 20'h2_0000)     return 4'b0010;
    if (a[31:8]  == 24'h40_0000)    return 4'b0100;
    if (a[31:16] == 16'h4000)       return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic void push(input int c, input int k, input logic [31:0] v, input string t);
    expT e;
    e.cyc = c; e.kind = k; e.val = v; e.tag = t;
    q.push_back(e);
  endfunction

  // Monitor: pops expectations as their cycle comes up
  always @(negedge clk) begin
    #5;
    while (q.size() > 0 && q[0].cyc <= cycNow) begin
      expT e;
      logic [31:0] act;
      e = q.pop_front();
      case (e.kind)
        0: act = {28'h0, slaveSel};
        1: act = {30'h0, hreadyOut, hresp};
        2: act = {31'h0, unmappedFlag};
        default: act = hrdata;
      endcase
      check(act, e.val, e.tag);
    end
  end

  // Driver: one address phase, plus the stall beat if it errors
  task automatic xfer(input logic [31:0] a, input logic [1:0] tr, input logic clr,
                      input logic stl, input string tag);
    logic [3:0] s;
    logic       hitMiss;
    int         c;
    @(negedge clk);
    c = cycNow;
    haddr = a; htrans = tr; unmappedClr = clr; stall = stl;
    s = refSel(a);
    hitMiss = tr[1] && !stl && (s == 4'b0000);
    push(c, 0, {28'h0, s}, {tag, " sel"});
    if (hitMiss) begin
      expFlag = 1'b1;
      push(c + 1, 1, 32'h1, {tag, " err beat1 (R3)"});
      push(c + 1, 2, 32'h1, {tag, " flag set (R7)"});
      push(c + 2, 1, 32'h3, {tag, " err beat2 (R3)"});
      push(c + 2, 2, 32'h1, {tag, " flag held (R7)"});
      push(c + 2, 3, 32'h0, {tag, " rdata zero (R4)"});
      @(negedge clk);
      // First error beat: a miss offered here is not accepted (R10)
      haddr = 32'hF000_0000; htrans = 2'b10; unmappedClr = 1'b0; stall = 1'b0;
    end else begin
      if (clr) expFlag = 1'b0;
      push(c + 1, 1, 32'h2, {tag, " okay"});
      push(c + 1, 2, {31'h0, expFlag}, {tag, " flag"});
    end
  endtask

  task automatic idleCycle();
    xfer(32'h0000_0000, 2'b00, 1'b0, 1'b0, "idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check({31'h0, hreadyOut}, 32'h1, "R9 hreadyOut in reset");
    check({31'h0, hresp}, 32'h0, "R9 hresp in reset");
    check({31'h0, unmappedFlag}, 32'h0, "R9 flag in reset");
    rstN = 1'b1;
    @(negedge clk);
    check({30'h0, hreadyOut, hresp}, 32'h2, "R9 okay after reset");

    xfer(32'h0000_1234, 2'b10, 1'b0, 1'b0, "R1 R6 region0 read");
    xfer(32'h0000_FFFC, 2'b11, 1'b0, 1'b0, "R1 region0 top");
    xfer(32'h2000_0FFC, 2'b10, 1'b0, 1'b0, "R1 region1 top");
    xfer(32'h4000_0010, 2'b10, 1'b0, 1'b0, "R1 overlap picks region2");
    xfer(32'h4000_0100, 2'b10, 1'b0, 1'b0, "R1 region3 above region2");
    xfer(32'h8000_0000, 2'b00, 1'b0, 1'b0, "R5 idle to unmapped");
    xfer(32'h8000_0004, 2'b01, 1'b0, 1'b0, "R5 busy to unmapped");
    xfer(32'h8000_0000, 2'b10, 1'b0, 1'b1, "R10 stalled miss");
    xfer(32'h2000_1000, 2'b10, 1'b0, 1'b0, "R2 R3 miss past region1");
    xfer(32'h0001_0000, 2'b10, 1'b0, 1'b0, "R11 back-to-back miss");
    xfer(32'h0000_0040, 2'b10, 1'b0, 1'b0, "R7 flag stays");
    xfer(32'h0000_0044, 2'b10, 1'b1, 1'b0, "R8 clear");
    xfer(32'h0000_0048, 2'b10, 1'b0, 1'b0, "R8 stays clear");
    xfer(32'h9000_0000, 2'b11, 1'b1, 1'b0, "R8 set wins over clear");
    xfer(32'h4001_0000, 2'b00, 1'b1, 1'b0, "R5 idle miss with clear");
    idleCycle();
    idleCycle();
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending items", q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule